// File: doc/BRIEF.md
# Machine Cycle Clock Manager

This block paces a processor core. It counts ticks of one of two base clocks and raises a one-cycle strobe each time a whole machine cycle has gone by. One base clock is the crystal and the other is an internal ring oscillator. Each base clock arrives as a clock-enable pulse on the single system clock. Software picks the ticks per machine cycle from three run-time ratios: 4 for full speed, 64 for the first power-saving speed and 1024 for the slowest. From the same cycle boundary the block derives one tick strobe per timer. Each timer counts either once per machine cycle (4 base clocks) or once per three machine cycles (12 base clocks).

The controls are level inputs that a register bank outside the block holds. The block takes a new ratio or a new source only at the end of a machine cycle, so no cycle is ever shortened. It checks the order of the steps back to full speed: the ratio must already be /4 and the crystal must report ready before the source returns to the crystal. The crystal amplifier may be off only while the ring oscillator is the active source. A hardware exit input restores full speed without any software write.

Top module: `mcyc_clk_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, the active ratio reads code 01 (/4), the source reads crystal (`stat_on_ring`=0), and `cyc_stb`, `tmr_stb` and `amp_off` are low.
- R2: `cyc_stb` pulses for one clock after every N ticks of the active source. N is 4 for ratio code 01, 64 for code 10 and 1024 for code 11. Code 00 is taken as code 01.
- R3: `stat_div` and `stat_on_ring` change only in the clock where `cyc_stb` is high. A new ratio therefore starts counting from zero at a cycle boundary.
- R4: While the ring is the active source, only `ring_en` ticks are counted and `xtal_en` is ignored. On the crystal the reverse holds.
- R5: With `ring_req`=1 and `hw_exit`=0, the source moves from crystal to ring at the next cycle boundary, with no precondition.
- R6: With `ring_req`=0, the source returns from ring to crystal at a boundary only if the active ratio at that boundary is /4 and `xtal_ready` is 1. A request for /4 and a request for the crystal made together therefore take two boundaries.
- R7: `amp_off` equals the ring being active AND `amp_off_req` AND NOT `hw_exit`. It is never high while the crystal is the active source.
- R8: `tmr_stb[i]` pulses only together with `cyc_stb`. If `timer_fast[i]`=1 it pulses with every `cyc_stb`. Otherwise it pulses with every third `cyc_stb` counted from reset, which is the 3rd, 6th and so on.
- R9: With `hw_exit`=1, the next boundary sets the ratio to /4 and ignores `div_code`. It also returns the source to the crystal in the same step if `xtal_ready` is 1; otherwise the source stays on the ring.
- R10: `stat_xtal_rdy` shows `xtal_ready` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 2 | Requested ratio: 01 /4, 10 /64, 11 /1024, 00 as /4 |
| ring_req | input | 1 | 1 requests the ring oscillator, 0 requests the crystal |
| amp_off_req | input | 1 | Request to power down the crystal amplifier |
| timer_fast | input | NTIMER | Per timer: 1 means one tick per machine cycle |
| hw_exit | input | 1 | Hardware return to full speed |
| xtal_ready | input | 1 | Crystal oscillator is stable |
| xtal_en | input | 1 | Crystal base-clock tick |
| ring_en | input | 1 | Ring oscillator base-clock tick |
| cyc_stb | output | 1 | Machine-cycle strobe |
| tmr_stb | output | NTIMER | Per-timer tick strobes |
| amp_off | output | 1 | Crystal amplifier shutdown |
| stat_xtal_rdy | output | 1 | Registered crystal-ready status |
| stat_on_ring | output | 1 | Active source is the ring oscillator |
| stat_div | output | 2 | Active ratio code |

## Verification
The base tick that completes a cycle and `cyc_stb` are one clock apart. The new `stat_div`/`stat_on_ring`, the timer strobes and the mod-3 timer phase all change on the same clock edge as `cyc_stb`. `amp_off` follows its inputs with no delay, and `stat_xtal_rdy` trails `xtal_ready` by one clock. The bench drives inputs on the falling edge. A reference model advances on the rising edge, and the bench compares every output on the following falling edge, before it drives again. Each output is therefore checked in exactly the cycle the requirements assign to it. The directed period checks count falling edges between consecutive strobes and compare the count with 4, 64 or 1024.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        DIV_ALIAS = 2'b00,
        DIV_4     = 2'b01,
        DIV_64    = 2'b10,
        DIV_1024  = 2'b11
    } div_sel_e;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_RING = 1'b1
    } clk_src_e;

    typedef struct packed {
        div_sel_e div;
        clk_src_e src;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{div: DIV_4, src: SRC_XTAL};

    // Code 00 is an alias of the full-speed ratio.
    function automatic div_sel_e norm_div(input logic [1:0] code);
        return (code == 2'b00) ? DIV_4 : div_sel_e'(code);
    endfunction

endpackage

// File: rtl/mcc_cfg_ctl.sv
module mcc_cfg_ctl
    import mcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     boundary,
    input  logic [1:0] req_div,
    input  logic     req_ring,
    input  logic     hw_exit,
    input  logic     xtal_ready,
    output clk_cfg_t cfg
);

    clk_cfg_t nxt;

    always_comb begin
        nxt = cfg;
        if (hw_exit) begin
            nxt.div = DIV_4;
            if (xtal_ready)
                nxt.src = SRC_XTAL;
        end else begin
            nxt.div = norm_div(req_div);
            if (req_ring)
                nxt.src = SRC_RING;
            else if (cfg.src == SRC_RING && cfg.div == DIV_4 && xtal_ready)
                nxt.src = SRC_XTAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (boundary)
            cfg <= nxt;
    end

endmodule

// File: rtl/mcc_cycle_div.sv
module mcc_cycle_div
    import mcc_pkg::*;
#(
    parameter int RATIO_LO  = 4,
    parameter int RATIO_MID = 64,
    parameter int RATIO_HI  = 1024
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t cfg,
    input  logic     xtal_en,
    input  logic     ring_en,
    output logic     boundary,
    output logic     cyc_stb
);

    localparam int CW = $clog2(RATIO_HI);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          tick;

    assign tick = (cfg.src == SRC_RING) ? ring_en : xtal_en;

    always_comb begin
        case (cfg.div)
            DIV_64:   limit = CW'(RATIO_MID - 1);
            DIV_1024: limit = CW'(RATIO_HI - 1);
            default:  limit = CW'(RATIO_LO - 1);
        endcase
    end

    assign boundary = tick && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cyc_stb <= 1'b0;
        end else begin
            cyc_stb <= boundary;
            if (boundary)
                cnt <= '0;
            else if (tick)
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mcc_tmr_ticks.sv
module mcc_tmr_ticks #(
    parameter int NTIMER    = 3,
    parameter int SLOW_MULT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic [NTIMER-1:0] fast,
    output logic [NTIMER-1:0] tmr_stb
);

    localparam int PW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;

    logic [PW-1:0]     phase;
    logic              slow_hit;
    logic [NTIMER-1:0] hit;

    assign slow_hit = (phase == PW'(SLOW_MULT - 1));

    for (genvar i = 0; i < NTIMER; i++) begin : g_tmr
        assign hit[i] = boundary && (fast[i] || slow_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            tmr_stb <= '0;
        end else begin
            tmr_stb <= hit;
            if (boundary)
                phase <= slow_hit ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/mcyc_clk_mgr.sv
module mcyc_clk_mgr
    import mcc_pkg::*;
#(
    parameter int NTIMER    = 3,
    parameter int RATIO_LO  = 4,
    parameter int RATIO_MID = 64,
    parameter int RATIO_HI  = 1024,
    parameter int SLOW_MULT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        div_code,
    input  logic              ring_req,
    input  logic              amp_off_req,
    input  logic [NTIMER-1:0] timer_fast,
    input  logic              hw_exit,
    input  logic              xtal_ready,
    input  logic              xtal_en,
    input  logic              ring_en,
    output logic              cyc_stb,
    output logic [NTIMER-1:0] tmr_stb,
    output logic              amp_off,
    output logic              stat_xtal_rdy,
    output logic              stat_on_ring,
    output logic [1:0]        stat_div
);

    clk_cfg_t cfg;
    logic     boundary;

    mcc_cfg_ctl i_cfg (
        .clk        (clk),
        .rst        (rst),
        .boundary   (boundary),
        .req_div    (div_code),
        .req_ring   (ring_req),
        .hw_exit    (hw_exit),
        .xtal_ready (xtal_ready),
        .cfg        (cfg)
    );

    mcc_cycle_div #(
        .RATIO_LO  (RATIO_LO),
        .RATIO_MID (RATIO_MID),
        .RATIO_HI  (RATIO_HI)
    ) i_div (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .xtal_en  (xtal_en),
        .ring_en  (ring_en),
        .boundary (boundary),
        .cyc_stb  (cyc_stb)
    );

    mcc_tmr_ticks #(
        .NTIMER    (NTIMER),
        .SLOW_MULT (SLOW_MULT)
    ) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .fast     (timer_fast),
        .tmr_stb  (tmr_stb)
    );

    assign amp_off      = (cfg.src == SRC_RING) && amp_off_req && !hw_exit;
    assign stat_on_ring = (cfg.src == SRC_RING);
    assign stat_div     = cfg.div;

    always_ff @(posedge clk) begin
        if (rst)
            stat_xtal_rdy <= 1'b0;
        else
            stat_xtal_rdy <= xtal_ready;
    end

endmodule

// File: rtl/mcyc_clk_mgr_chk.sv
module mcyc_clk_mgr_chk #(
    parameter int NTIMER = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_exit,
    input logic              xtal_ready,
    input logic              cyc_stb,
    input logic [NTIMER-1:0] tmr_stb,
    input logic              amp_off,
    input logic              stat_xtal_rdy,
    input logic              stat_on_ring,
    input logic [1:0]        stat_div
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (stat_div == 2'b01 && !stat_on_ring && !cyc_stb && tmr_stb == '0)); // R1

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (!$stable(stat_div) || !$stable(stat_on_ring)) |-> cyc_stb); // R3

    AST_RING_EXIT_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_on_ring) |-> ($past(stat_div) == 2'b01 || $past(hw_exit))); // R6

    AST_RING_EXIT_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_on_ring) |-> $past(xtal_ready)); // R6

    AST_AMP_ONLY_RING: assert property (@(posedge clk) disable iff (rst)
        amp_off |-> stat_on_ring); // R7

    AST_TMR_WITH_CYC: assert property (@(posedge clk) disable iff (rst)
        (|tmr_stb) |-> cyc_stb); // R8

    AST_HW_EXIT_DIV: assert property (@(posedge clk) disable iff (rst)
        (hw_exit && cyc_stb && $past(hw_exit)) |-> stat_div == 2'b01); // R9

    AST_RDY_HIGH: assert property (@(posedge clk) disable iff (rst)
        xtal_ready |=> stat_xtal_rdy); // R10

    AST_RDY_LOW: assert property (@(posedge clk) disable iff (rst)
        !xtal_ready |=> !stat_xtal_rdy); // R10

endmodule

bind mcyc_clk_mgr mcyc_clk_mgr_chk #(.NTIMER(NTIMER)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .hw_exit       (hw_exit),
    .xtal_ready    (xtal_ready),
    .cyc_stb       (cyc_stb),
    .tmr_stb       (tmr_stb),
    .amp_off       (amp_off),
    .stat_xtal_rdy (stat_xtal_rdy),
    .stat_on_ring  (stat_on_ring),
    .stat_div      (stat_div)
);

// File: tb/test_mcyc_clk_mgr.sv
`timescale 1ns/1ps
module test_mcyc_clk_mgr;

    localparam int NT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    div_code = 2'b01;
    logic          ring_req = 1'b0;
    logic          amp_off_req = 1'b0;
    logic [NT-1:0] timer_fast = '0;
    logic          hw_exit = 1'b0;
    logic          xtal_ready = 1'b1;
    logic          xtal_en = 1'b1;
    logic          ring_en = 1'b1;
    logic          cyc_stb;
    logic [NT-1:0] tmr_stb;
    logic          amp_off;
    logic          stat_xtal_rdy;
    logic          stat_on_ring;
    logic [1:0]    stat_div;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcyc_clk_mgr #(.NTIMER(NT)) i_mcyc_clk_mgr (
        .clk(clk), .rst(rst), .div_code(div_code), .ring_req(ring_req),
        .amp_off_req(amp_off_req), .timer_fast(timer_fast), .hw_exit(hw_exit),
        .xtal_ready(xtal_ready), .xtal_en(xtal_en), .ring_en(ring_en),
        .cyc_stb(cyc_stb), .tmr_stb(tmr_stb), .amp_off(amp_off),
        .stat_xtal_rdy(stat_xtal_rdy), .stat_on_ring(stat_on_ring), .stat_div(stat_div)
    );

    // Reference model built from the requirements
    logic [1:0]    m_div = 2'b01;
    logic          m_ring = 1'b0;
    int            m_cnt = 0;
    int            m_cyc_no = 0;
    logic          e_cyc = 1'b0;
    logic [NT-1:0] e_tmr = '0;
    logic          e_rdy = 1'b0;

    function automatic int ratio_of(input logic [1:0] c);
        case (c)
            2'b10:   return 64;
            2'b11:   return 1024;
            default: return 4;
        endcase
    endfunction

    function automatic logic [1:0] norm(input logic [1:0] c);
        return (c == 2'b00) ? 2'b01 : c;
    endfunction

    always @(posedge clk) begin
        logic tk;
        logic fin;
        tk  = m_ring ? ring_en : xtal_en;
        fin = tk && (m_cnt == ratio_of(m_div) - 1);
        if (rst) begin
            m_div <= 2'b01; m_ring <= 1'b0; m_cnt <= 0; m_cyc_no <= 0;
            e_cyc <= 1'b0; e_tmr <= '0; e_rdy <= 1'b0;
        end else begin
            e_rdy <= xtal_ready;
            e_cyc <= fin;
            for (int i = 0; i < NT; i++)
                e_tmr[i] <= fin && (timer_fast[i] || ((m_cyc_no + 1) % 3 == 0));
            if (fin) begin
                m_cnt <= 0;
                m_cyc_no <= m_cyc_no + 1;
                if (hw_exit) begin
                    m_div <= 2'b01;
                    if (xtal_ready) m_ring <= 1'b0;
                end else begin
                    m_div <= norm(div_code);
                    if (ring_req) m_ring <= 1'b1;
                    else if (m_ring && m_div == 2'b01 && xtal_ready) m_ring <= 1'b0;
                end
            end else if (tk) begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        miscompares++;
        $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    endtask

    // One falling edge: compare every output against the model.
    task automatic step();
        logic e_amp;
        @(negedge clk);
        cycles++;
        vectors++;
        e_amp = m_ring && amp_off_req && !hw_exit;
        if (cyc_stb !== e_cyc)        fail_line("R2/R4", "cyc_stb", cyc_stb, e_cyc);
        if (tmr_stb !== e_tmr)        fail_line("R8", "tmr_stb", tmr_stb, e_tmr);
        if (stat_div !== m_div)       fail_line("R3/R9", "stat_div", stat_div, m_div);
        if (stat_on_ring !== m_ring)  fail_line("R5/R6", "stat_on_ring", stat_on_ring, m_ring);
        if (amp_off !== e_amp)        fail_line("R7", "amp_off", amp_off, e_amp);
        if (!rst && stat_xtal_rdy !== e_rdy)
            fail_line("R10", "stat_xtal_rdy", stat_xtal_rdy, e_rdy);
    endtask

    // R2 / R4: measure strobe period on a chosen source.
    task automatic measure(input logic [1:0] code, input logic ring, input int exp);
        int gap;
        int guard;
        hw_exit = 1'b0; xtal_ready = 1'b1; amp_off_req = 1'b0;
        xtal_en = 1'b1; ring_en = 1'b1;
        div_code = ring ? code : 2'b01;
        ring_req = ring;
        guard = 0;
        while ((stat_on_ring !== ring || stat_div !== 2'b01) && guard < 5000) begin
            step(); guard++;
        end
        div_code = code;
        guard = 0;
        while (stat_div !== norm(code) && guard < 5000) begin step(); guard++; end
        xtal_en = !ring; ring_en = ring;
        guard = 0;
        do begin step(); guard++; end while (cyc_stb !== 1'b1 && guard < 5000);
        gap = 0;
        do begin step(); gap++; end while (cyc_stb !== 1'b1 && gap < 5000);
        vectors++;
        if (gap != exp) fail_line(ring ? "R4" : "R2", "period", gap, exp);
        xtal_en = 1'b1; ring_en = 1'b1;
    endtask

    task automatic wait_stb();
        int guard = 0;
        do begin step(); guard++; end while (cyc_stb !== 1'b1 && guard < 5000);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with hostile inputs
        ring_req = 1'b1; amp_off_req = 1'b1; div_code = 2'b11; timer_fast = '1;
        for (int i = 0; i < 4; i++) begin
            step();
            vectors++;
            if (cyc_stb !== 1'b0 || stat_div !== 2'b01 || stat_on_ring !== 1'b0 || amp_off !== 1'b0)
                fail_line("R1", "reset state", {stat_div, stat_on_ring, amp_off, cyc_stb}, 5'b01000);
        end
        ring_req = 1'b0; amp_off_req = 1'b0; div_code = 2'b01; timer_fast = '0;
        rst = 1'b0;

        // R2: all ratio codes on the crystal, including the 00 alias
        measure(2'b01, 1'b0, 4);
        measure(2'b00, 1'b0, 4);
        measure(2'b10, 1'b0, 64);
        measure(2'b11, 1'b0, 1024);
        // R4: ring as source, crystal ticks absent
        measure(2'b01, 1'b1, 4);
        measure(2'b10, 1'b1, 64);

        // R6: ring at /64, crystal requested, must stay on ring
        ring_req = 1'b0; xtal_ready = 1'b1; div_code = 2'b10;
        wait_stb(); wait_stb();
        vectors++;
        if (stat_on_ring !== 1'b1) fail_line("R6", "left ring at /64", stat_on_ring, 1);
        div_code = 2'b01;
        wait_stb();
        vectors++;
        if (stat_on_ring !== 1'b1 || stat_div !== 2'b01)
            fail_line("R6", "first step of exit", {stat_div, stat_on_ring}, 3'b011);
        wait_stb();
        vectors++;
        if (stat_on_ring !== 1'b0) fail_line("R6", "second step of exit", stat_on_ring, 0);

        // R5 / R7: enter ring, amplifier off, then hardware exit (R9)
        ring_req = 1'b1; div_code = 2'b11; amp_off_req = 1'b1;
        wait_stb();
        vectors++;
        if (stat_on_ring !== 1'b1 || amp_off !== 1'b1)
            fail_line("R5", "ring entry", {stat_on_ring, amp_off}, 2'b11);
        hw_exit = 1'b1; xtal_ready = 1'b0;
        step();
        vectors++;
        if (amp_off !== 1'b0) fail_line("R7", "amp_off during hw_exit", amp_off, 0);
        wait_stb();
        vectors++;
        if (stat_div !== 2'b01 || stat_on_ring !== 1'b1)
            fail_line("R9", "exit without ready", {stat_div, stat_on_ring}, 3'b011);
        xtal_ready = 1'b1;
        wait_stb();
        vectors++;
        if (stat_on_ring !== 1'b0) fail_line("R9", "exit with ready", stat_on_ring, 0);
        hw_exit = 1'b0; ring_req = 1'b0; amp_off_req = 1'b0;

        // Constrained random: model compares every cycle (R2..R10)
        for (int i = 0; i < 60000; i++) begin
            step();
            xtal_en = ($urandom % 4) != 0;
            ring_en = ($urandom % 2) != 0;
            if (i % 1500 == 0) begin
                div_code    = 2'($urandom);
                ring_req    = ($urandom % 2) != 0;
                amp_off_req = ($urandom % 2) != 0;
                timer_fast  = NT'($urandom);
                hw_exit     = ($urandom % 6) == 0;
            end
            if (i % 97 == 0) xtal_ready = ($urandom % 4) != 0;
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule